// File: doc/BRIEF.md
# Handshake Bus Wait-State Generator

This block stalls a fast 8-bit processor bus for as long as a slow peripheral needs, and for no longer. The processor's `rdy` line is positive logic: high lets the current bus cycle complete, and low holds it. When the decoded select of the slow device is found high at a processor clock edge, the block pulls `rdy` low. It keeps `rdy` low until the peripheral reports completion with a transition on its asynchronous `done` line. Cycles that go to memory or to fast devices leave `rdy` high and see no wait state.

The completion line is first resynchronised into the processor clock domain, then reduced to a one-cycle acknowledge pulse. A level that stays asserted therefore cannot release more than one access. After a release, the next clock edge is the one on which the processor closes the stalled cycle, so the select seen at that edge belongs to the old access. A select still high on the edge after that starts a new access, and that access needs its own fresh completion transition. A completion transition that arrives while nothing is pending is dropped.

There is no data stream through this block. Every pin is a plain control line with no valid/ready flow control.

Top module: `handshake_wait_gen`

## Requirements
- R1: During reset and on the first cycle after it, `rdy` is high and no wait is pending.
- R2: When `slow_sel` is high at a rising clock edge while the block is idle, `rdy` is low after that edge.
- R3: When `slow_sel` is low at an edge while `rdy` is high, `rdy` stays high after that edge, so fast or memory cycles get no wait state.
- R4: While a wait is pending, `rdy` stays low until a completion transition is detected. When `done` (active high by default) rises before clock edge E, `rdy` is high after edge E+2.
- R5: Completion is recognised only on a low-to-high transition of `done`. A `done` held high from an earlier access does not release a later access, however long it stays high.
- R6: Each completion transition releases exactly one access. On the edge after the release `rdy` stays high whatever `slow_sel` is, because the processor closes the stalled cycle there. If `slow_sel` is still high on the following edge, a new wait starts (back-to-back slow cycles).
- R7: A completion transition that arrives while no wait is pending is ignored and not remembered. A later access still stalls until its own transition.
- R8: A `done` high pulse lasting one clock period is enough to release a pending access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| slow_sel | input | 1 | Decoded select of the slow peripheral for the current bus cycle |
| done_async | input | 1 | Completion line from the peripheral, asynchronous to `clk` |
| rdy | output | 1 | Processor ready: high lets the cycle finish, low stalls it |

## Verification
A controller stuck in its stall state shows at the port as `rdy` staying low past the second edge after a completion transition. A controller that returns to idle too early shows as `rdy` rising on an edge with no transition behind it. A broken edge detector releases a second access under a held `done`, or fails to release one at all. An acknowledge left over from an idle period releases the next access on its first or second cycle. All of these appear at `rdy` within three clock cycles of the stimulus that exposes them.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  // Controller phases of one slow access
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,  // no slow access open
    WS_STALL = 2'd1,  // ready held low, waiting for completion
    WS_CLOSE = 2'd2   // released; processor finishes the cycle on this edge
  } ws_state_e;

endpackage

// File: rtl/wsg_sync.sv
module wsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d_in};
      end
    end
  endgenerate

  assign q_out = chain[LAST];

endmodule

// File: rtl/wsg_edge.sv
module wsg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic pulse_out
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end

  // one cycle per low-to-high transition, however long the level holds
  assign pulse_out = level_in & ~prev_q;

endmodule

// File: rtl/wsg_ctrl.sv
module wsg_ctrl
  import wsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_in,
  input  logic ack_in,
  output logic rdy_out,
  output logic idle_out
);

  ws_state_e state_q, state_d;
  logic      rdy_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      WS_IDLE:  if (sel_in) state_d = WS_STALL;
      WS_STALL: if (ack_in) state_d = WS_CLOSE;
      WS_CLOSE: state_d = WS_IDLE;
      default:  state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      rdy_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      rdy_q   <= (state_d != WS_STALL);
    end
  end

  assign rdy_out  = rdy_q;
  assign idle_out = (state_q == WS_IDLE);

endmodule

// File: rtl/handshake_wait_gen.sv
module handshake_wait_gen #(
  parameter int SYNC_STAGES      = 2,
  parameter bit DONE_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  input  logic done_async,
  output logic rdy
);

  logic done_lvl;
  logic done_sync;
  logic ack_pulse;
  logic ctrl_idle;

  generate
    if (DONE_ACTIVE_HIGH) begin : g_pos
      assign done_lvl = done_async;
    end else begin : g_neg
      assign done_lvl = ~done_async;
    end
  endgenerate

  wsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (done_lvl),
    .q_out (done_sync)
  );

  wsg_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_in  (done_sync),
    .pulse_out (ack_pulse)
  );

  wsg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_in   (slow_sel),
    .ack_in   (ack_pulse),
    .rdy_out  (rdy),
    .idle_out (ctrl_idle)
  );

endmodule

// File: rtl/wsg_chk.sv
module wsg_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic ack,
  input logic rdy,
  input logic idle
);

  // R2
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sel) |=> !rdy);

  // R3
  fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !sel) |=> rdy);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && !ack) |=> !rdy);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && ack) |=> rdy);

  // R5
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R6
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |=> rdy);

endmodule

bind handshake_wait_gen wsg_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .sel   (slow_sel),
  .ack   (ack_pulse),
  .rdy   (rdy),
  .idle  (ctrl_idle)
);

// File: tb/handshake_wait_gen_test.sv
module handshake_wait_gen_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_sel = 1'b0;
  logic done_async = 1'b0;
  logic rdy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    bit    exp;
    string tag;
  } item_t;

  item_t sbq[$];

  always #2 clk = ~clk;  // 250 MHz

  handshake_wait_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_sel   (slow_sel),
    .done_async (done_async),
    .rdy        (rdy)
  );

  // driver: set inputs before an edge, queue the rdy expected after it
  task automatic cyc(input bit s, input bit d, input bit e, input string t);
    @(negedge clk);
    slow_sel   = s;
    done_async = d;
    sbq.push_back('{exp: e, tag: t});
  endtask

  // monitor: compare one queued item shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (rdy !== it.exp) begin
          errors++;
          $display("FAIL %s: rdy=%b expected=%b at %0t", it.tag, rdy, it.exp, $time);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rdy !== 1'b1) begin
      errors++;
      $display("FAIL R1: rdy=%b expected=1 during reset", rdy);
    end
    rst_n = 1'b1;

    // R1 / R3: reset state and fast cycles
    cyc(0, 0, 1, "R1");
    cyc(0, 0, 1, "R3");
    cyc(0, 0, 1, "R3");

    // R2 / R4: single slow access, three idle stall cycles
    cyc(1, 0, 0, "R2");
    repeat (3) cyc(1, 0, 0, "R4 hold");
    cyc(1, 1, 0, "R4 sync");
    cyc(1, 1, 0, "R4 sync");
    cyc(1, 1, 1, "R4 release");
    cyc(1, 1, 1, "R6 close");
    cyc(0, 1, 1, "R3");

    // R5: done still held high from previous access
    cyc(1, 1, 0, "R2");
    repeat (6) cyc(1, 1, 0, "R5 held level");
    cyc(1, 0, 0, "R5");
    cyc(1, 0, 0, "R5");
    cyc(1, 1, 0, "R5");
    cyc(1, 0, 0, "R5");
    cyc(1, 0, 1, "R5 fresh edge releases");

    // R6: back-to-back slow accesses with select held
    cyc(1, 0, 1, "R6 close");
    cyc(1, 0, 0, "R6 rearm");
    cyc(1, 0, 0, "R4 hold");
    cyc(1, 0, 0, "R4 hold");

    // R8: one-clock done pulse
    cyc(1, 1, 0, "R8");
    cyc(1, 0, 0, "R8");
    cyc(1, 0, 1, "R8 release");
    cyc(0, 0, 1, "R6 close");

    // R7: done edge while idle is dropped
    cyc(0, 1, 1, "R7");
    cyc(0, 1, 1, "R7");
    cyc(0, 0, 1, "R7");
    cyc(0, 0, 1, "R7");
    cyc(0, 0, 1, "R7");
    cyc(1, 0, 0, "R7 arm");
    repeat (5) cyc(1, 0, 0, "R7 not remembered");
    cyc(1, 1, 0, "R4");
    cyc(1, 0, 0, "R4");
    cyc(1, 0, 1, "R4 release");
    cyc(0, 0, 1, "R6 close");

    // R3: interleaved fast cycles
    cyc(0, 0, 1, "R3");
    cyc(0, 1, 1, "R3");
    cyc(0, 0, 1, "R3");

    wait (sbq.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule